// File: doc/BRIEF.md
# Self-Recovering Modified One-Hot Sequencer

This block steps through eight states in a fixed ring and keeps its state in seven flip-flops. The all-zero vector is a legal state, state 0. Each of states 1 to 7 sets exactly one bit: state k sets bit k-1. The flip-flops form a shift chain. Bit 0 is refilled from the NOR of the whole vector, so an empty chain starts a new token on its own. Any surplus ones drift toward the top and drop off the end. No homing logic is needed.

An advance input moves the chain one place. A load port writes an arbitrary vector into the chain, which is how upsets are injected or a start state is chosen. A one-hot decoded state output drives the rest of the design. A warning flag rises whenever the chain holds two or more ones. A single 1-to-0 upset on a legal state cannot be seen, because it always lands on state 0, which is legal. For that reason no parity bit is kept.

Top module: `mohs_sequencer`

## Requirements
- R1: A synchronous reset clears every chain bit, giving state 0 (`state_vec` = 0, `state_oh` = 1), and takes priority over load and advance.
- R2: With `rst`, `load_en` and `adv_en` all low, the chain keeps its value unchanged.
- R3: With `adv_en` high and `load_en` low, bit i+1 takes the old bit i, and bit 0 takes 1 exactly when the old vector was all zero.
- R4: When advanced from reset, the chain visits states 0,1,2,...,7 and then returns to 0, where state k (k ≥ 1) is the vector with only bit k-1 set.
- R5: `state_oh` has bit k set for legal state k and no other bit set; for a vector with two or more ones it is all zero.
- R6: `multi_warn` is high exactly when two or more bits of `state_vec` are set. It is combinational from the chain.
- R7: With `load_en` high, the chain takes `load_val` on the next edge, even if `adv_en` is high.
- R8: From any of the 128 vectors, at most seven advances reach a legal vector (at most one bit set). After that, advancing never leaves the legal ring.
- R9: Clearing the set bit of any legal state gives state 0 with `multi_warn` low. The upset is silently accepted as a legal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Advance the chain by one place |
| load_en | input | 1 | Write `load_val` into the chain |
| load_val | input | NUM_STATES-1 | Vector to be loaded |
| state_vec | output | NUM_STATES-1 | Raw chain contents |
| state_oh | output | NUM_STATES | One-hot decoded state, all zero when corrupted |
| multi_warn | output | 1 | Two or more chain bits set |

## Verification
The bench builds the block with the default eight states, so the chain is seven bits wide and its whole space is only 128 vectors. That size puts every possible corruption within reach of a full sweep. Each vector is loaded and then advanced fifteen times. Every step is compared with an arithmetic model (double modulo 128, plus one when the vector is zero), and the legality bound is checked after the seventh step.

// File: rtl/mohs_pkg.sv
package mohs_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_STEP = 2'd1,
    MODE_LOAD = 2'd2,
    MODE_CLR  = 2'd3
  } chain_mode_e;
endpackage

// File: rtl/mohs_chain.sv
module mohs_chain
  import mohs_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_en,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] chain_q
);
  chain_mode_e  mode;
  logic         empty_w;
  logic [W-1:0] shifted_w;
  logic [W-1:0] next_w;

  function automatic logic refill(input logic [W-1:0] v);
    return ~(|v);
  endfunction

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] v, input logic b);
    logic [W-1:0] r;
    r = v << 1;
    r[0] = b;
    return r;
  endfunction

  always_comb begin
    if (rst)          mode = MODE_CLR;
    else if (load_en) mode = MODE_LOAD;
    else if (adv_en)  mode = MODE_STEP;
    else              mode = MODE_HOLD;
  end

  assign empty_w   = refill(chain_q);
  assign shifted_w = shift_in(chain_q, empty_w);

  always_comb begin
    unique case (mode)
      MODE_CLR:  next_w = '0;
      MODE_LOAD: next_w = load_val;
      MODE_STEP: next_w = shifted_w;
      default:   next_w = chain_q;
    endcase
  end

  always_ff @(posedge clk) begin
    chain_q <= next_w;
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !adv_en) |=> $stable(chain_q));

  // R3
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !load_en) |=> chain_q[W-1:1] == $past(chain_q[W-2:0]));

  // R3
  refill_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !load_en) |=> chain_q[0] == ($past(chain_q) == '0));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> chain_q == $past(load_val));
endmodule

// File: rtl/mohs_decode.sv
module mohs_decode #(
  parameter int W = 7
) (
  input  logic [W-1:0] vec,
  output logic [W:0]   onehot
);
  assign onehot[0] = ~(|vec);

  for (genvar k = 1; k <= W; k++) begin : g_dec
    localparam logic [W-1:0] MASK = {{(W-1){1'b0}}, 1'b1} << (k - 1);
    assign onehot[k] = vec[k-1] & ~(|(vec & ~MASK));
  end
endmodule

// File: rtl/mohs_multi_det.sv
module mohs_multi_det #(
  parameter int W = 7
) (
  input  logic [W-1:0] vec,
  output logic         multi
);
  logic [W-1:0] seen;
  logic [W-1:0] dup;

  assign seen[0] = vec[0];
  assign dup[0]  = 1'b0;

  for (genvar i = 1; i < W; i++) begin : g_scan
    assign seen[i] = seen[i-1] | vec[i];
    assign dup[i]  = dup[i-1] | (seen[i-1] & vec[i]);
  end

  assign multi = dup[W-1];

  // R6
  always_comb begin
    multi_count_chk: assert (multi == ($countones(vec) >= 2));
  end
endmodule

// File: rtl/mohs_sequencer.sv
module mohs_sequencer #(
  parameter int NUM_STATES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv_en,
  input  logic                  load_en,
  input  logic [NUM_STATES-2:0] load_val,
  output logic [NUM_STATES-2:0] state_vec,
  output logic [NUM_STATES-1:0] state_oh,
  output logic                  multi_warn
);
  localparam int CHAIN_W = NUM_STATES - 1;

  logic [CHAIN_W-1:0] chain_w;
  logic [CHAIN_W:0]   dec_w;
  logic               multi_w;

  mohs_chain #(.W(CHAIN_W)) chain_i (
    .clk      (clk),
    .rst      (rst),
    .adv_en   (adv_en),
    .load_en  (load_en),
    .load_val (load_val),
    .chain_q  (chain_w)
  );

  mohs_decode #(.W(CHAIN_W)) decode_i (
    .vec    (chain_w),
    .onehot (dec_w)
  );

  mohs_multi_det #(.W(CHAIN_W)) det_i (
    .vec   (chain_w),
    .multi (multi_w)
  );

  assign state_vec  = chain_w;
  assign state_oh   = dec_w;
  assign multi_warn = multi_w;

  // R5
  legal_decode_chk: assert property (@(posedge clk) disable iff (rst)
    !multi_w |-> $onehot(dec_w));

  // R5
  corrupt_decode_chk: assert property (@(posedge clk) disable iff (rst)
    multi_w |-> dec_w == '0);

  // R8
  ring_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (!multi_w && !load_en) |=> !multi_w);

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_w[CHAIN_W] && adv_en && !load_en) |=> dec_w[0]);
endmodule

// File: tb/mohs_sequencer_tb_top.sv
module mohs_sequencer_tb_top;
  localparam int N = 8;
  localparam int W = N - 1;
  localparam int SPAN = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b0;
  logic         adv_en = 1'b0;
  logic         load_en = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] state_vec;
  logic [N-1:0] state_oh;
  logic         multi_warn;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  mohs_sequencer #(.NUM_STATES(N)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .adv_en     (adv_en),
    .load_en    (load_en),
    .load_val   (load_val),
    .state_vec  (state_vec),
    .state_oh   (state_oh),
    .multi_warn (multi_warn)
  );

  function automatic int model_next(input int v);
    return ((v * 2) % SPAN) + ((v == 0) ? 1 : 0);
  endfunction

  function automatic int ones(input int v);
    int c = 0;
    for (int i = 0; i < W; i++) c += (v >> i) & 1;
    return c;
  endfunction

  function automatic int model_oh(input int v);
    if (v == 0) return 1;
    if (ones(v) != 1) return 0;
    for (int i = 0; i < W; i++) if (v == (1 << i)) return 1 << (i + 1);
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int v);
    chk(req, int'(state_vec), v);
    chk({req, "/R5"}, int'(state_oh), model_oh(v));
    chk({req, "/R6"}, int'(multi_warn), (ones(v) >= 2) ? 1 : 0);
  endtask

  task automatic tick(input logic r, input logic a, input logic l, input int val);
    rst = r; adv_en = a; load_en = l; load_val = W'(val);
    @(posedge clk);
    #1;
    rst = 1'b0; adv_en = 1'b0; load_en = 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int v;
    #1;
    // R1 reset state
    tick(1'b1, 1'b0, 1'b0, 0);
    chk_all("R1", 0);

    // R4 walk the legal ring twice
    for (int s = 1; s <= 16; s++) begin
      tick(1'b0, 1'b1, 1'b0, 0);
      v = s % N;
      chk("R4", int'(state_oh), 1 << v);
      chk("R3", int'(state_vec), (v == 0) ? 0 : (1 << (v - 1)));
    end

    // R2 hold
    tick(1'b0, 1'b1, 1'b0, 0);
    tick(1'b0, 1'b1, 1'b0, 0);
    for (int h = 0; h < 4; h++) begin
      tick(1'b0, 1'b0, 1'b0, 0);
      chk("R2", int'(state_vec), 2);
    end

    // R7 load beats advance
    tick(1'b0, 1'b1, 1'b1, 7'h55);
    chk_all("R7", 7'h55);

    // R1 reset beats load and advance
    tick(1'b1, 1'b1, 1'b1, 7'h7F);
    chk_all("R1", 0);

    // R9 single 1-to-0 upset of each legal state
    for (int k = 0; k < W; k++) begin
      tick(1'b0, 1'b0, 1'b1, 1 << k);
      chk_all("R9", 1 << k);
      tick(1'b0, 1'b0, 1'b1, 0);
      chk_all("R9", 0);
    end

    // R8 exhaustive sweep of all vectors
    for (int start = 0; start < SPAN; start++) begin
      tick(1'b0, 1'b0, 1'b1, start);
      chk_all("R7", start);
      v = start;
      for (int st = 1; st <= 15; st++) begin
        tick(1'b0, 1'b1, 1'b0, 0);
        v = model_next(v);
        chk_all("R3", v);
        if (st >= 7) chk("R8", (ones(int'(state_vec)) <= 1) ? 1 : 0, 1);
      end
    end

    report();
  end
endmodule